// File: doc/BRIEF.md
# Banked RAM Address Mapper

This block turns a 16-bit processor address into a wider RAM address by prefixing it with bank bits. The bank bits come from a small control register that software writes and can read back. When the memory slot belongs to the processor, the register picks one of four 64 KiB address spaces. When the slot belongs to the display engine, the register is ignored and the top bank is forced, so video memory stays at a fixed place while the processor is free to map any bank.

The RAM address is formed combinationally from the address presented in the current slot, the slot owner flag, and the current register contents. A register write lands at the next clock edge, so it applies from the following access onward. A read strobe copies the register to a readback output at the next edge, where it stays until the next read. This lets an interrupt handler save the bank and restore it later.

Top module: `bank_ram_mapper`

## Requirements
- R1: While reset (rstN low) is applied and afterwards until the first write, the bank register holds 0: processor-slot accesses map to bank 0 and rdData reads 0.
- R2: ramAddr[15:0] always equals reqAddr, in processor and display slots alike.
- R3: In a processor slot (dispSlot = 0), ramAddr[17:16] equals the current bank register value.
- R4: In a display slot (dispSlot = 1), ramAddr[17:16] is 2'b11 whatever the register holds.
- R5: A write strobe (wrEn high for one clock) loads wrData[1:0] into the bank register at that clock edge. An access in the same cycle still uses the old bank, and processor accesses from the next cycle use the new one.
- R6: A write made during a display slot does not change the display bank in that cycle (still 2'b11). Later processor accesses use the written value.
- R7: A display slot leaves no trace. The next processor access maps to the register's bank, not to 2'b11.
- R8: A read strobe (rdEn high) copies the bank register into rdData at that clock edge. A read in the same cycle as a write returns the old value. Without rdEn, rdData holds its value.
- R9: Without wrEn, the bank register keeps its value across any mix of slots, addresses and reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqAddr | input | 16 | Address of the current access (processor or display) |
| dispSlot | input | 1 | 1 when the display engine owns the current slot |
| wrEn | input | 1 | Bank register write strobe |
| wrData | input | 2 | Value to load into the bank register |
| rdEn | input | 1 | Bank register read strobe |
| rdData | output | 2 | Captured bank register value |
| ramAddr | output | 18 | Banked RAM address: bank in [17:16], reqAddr in [15:0] |

## Verification
The bench targets these cases:
- A write and an access in the same cycle. A design that forwards the write data would map that access to the new bank a cycle too early.
- Writes made inside display slots, alternating with processor slots. If the forced bank leaked into the register, or the register leaked into the display bank, processor accesses would land in bank 3 or video accesses would move.
- A read in the same cycle as a write. Returning the new value there would break save-and-restore.
- Long runs with no strobes. These show that rdData and the bank hold their values.

// File: rtl/bank_ram_mapper_pkg.sv
package bank_ram_mapper_pkg;

  typedef struct packed {
    logic loadBank;
    logic captureRd;
    logic forceDisp;
  } mapStrobes_t;

endpackage

// File: rtl/bank_ram_mapper_ctrl.sv
module bank_ram_mapper_ctrl
  import bank_ram_mapper_pkg::*;
(
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic        dispSlot,
  output mapStrobes_t strobes
);

  always_comb begin
    strobes           = '0;
    strobes.loadBank  = wrEn;
    strobes.captureRd = rdEn;
    strobes.forceDisp = dispSlot;
  end

endmodule

// File: rtl/bank_ram_mapper_dp.sv
module bank_ram_mapper_dp
  import bank_ram_mapper_pkg::*;
#(
  parameter int CPU_AW = 16,
  parameter int BANK_W = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  mapStrobes_t              strobes,
  input  logic [CPU_AW-1:0]        reqAddr,
  input  logic [BANK_W-1:0]        wrData,
  output logic [BANK_W-1:0]        rdData,
  output logic [CPU_AW+BANK_W-1:0] ramAddr
);

  localparam logic [BANK_W-1:0] DISP_BANK = '1;

  logic [BANK_W-1:0] bankReg;
  logic [BANK_W-1:0] bankSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankReg <= '0;
    end else if (strobes.loadBank) begin
      bankReg <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strobes.captureRd) begin
      rdData <= bankReg;
    end
  end

  always_comb begin
    bankSel = strobes.forceDisp ? DISP_BANK : bankReg;
    ramAddr = {bankSel, reqAddr};
  end

endmodule

// File: rtl/bank_ram_mapper.sv
module bank_ram_mapper
  import bank_ram_mapper_pkg::*;
#(
  parameter int CPU_AW = 16,
  parameter int BANK_W = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [CPU_AW-1:0]        reqAddr,
  input  logic                     dispSlot,
  input  logic                     wrEn,
  input  logic [BANK_W-1:0]        wrData,
  input  logic                     rdEn,
  output logic [BANK_W-1:0]        rdData,
  output logic [CPU_AW+BANK_W-1:0] ramAddr
);

  mapStrobes_t strobes;

  bank_ram_mapper_ctrl u_ctrl (
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .dispSlot (dispSlot),
    .strobes  (strobes)
  );

  bank_ram_mapper_dp #(
    .CPU_AW (CPU_AW),
    .BANK_W (BANK_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .reqAddr (reqAddr),
    .wrData  (wrData),
    .rdData  (rdData),
    .ramAddr (ramAddr)
  );

endmodule

// File: rtl/bank_ram_mapper_chk.sv
module bank_ram_mapper_chk #(
  parameter int CPU_AW = 16,
  parameter int BANK_W = 2
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [CPU_AW-1:0]        reqAddr,
  input logic                     dispSlot,
  input logic                     wrEn,
  input logic [BANK_W-1:0]        wrData,
  input logic                     rdEn,
  input logic [BANK_W-1:0]        rdData,
  input logic [CPU_AW+BANK_W-1:0] ramAddr
);

  localparam int TOP = CPU_AW + BANK_W - 1;

  p_low_pass_r2: assert property (@(posedge clk) disable iff (!rstN)
    ramAddr[CPU_AW-1:0] == reqAddr);

  p_disp_bank_r4: assert property (@(posedge clk) disable iff (!rstN)
    dispSlot |-> ramAddr[TOP:CPU_AW] == {BANK_W{1'b1}});

  p_write_lands_r5: assert property (@(posedge clk) disable iff (!rstN)
    wrEn ##1 !dispSlot |-> ramAddr[TOP:CPU_AW] == $past(wrData));

  p_bank_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !dispSlot) ##1 !dispSlot |-> $stable(ramAddr[TOP:CPU_AW]));

  p_read_capture_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !dispSlot) |=> rdData == $past(ramAddr[TOP:CPU_AW]));

  p_read_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

endmodule

bind bank_ram_mapper bank_ram_mapper_chk #(
  .CPU_AW (CPU_AW),
  .BANK_W (BANK_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqAddr  (reqAddr),
  .dispSlot (dispSlot),
  .wrEn     (wrEn),
  .wrData   (wrData),
  .rdEn     (rdEn),
  .rdData   (rdData),
  .ramAddr  (ramAddr)
);

// File: tb/test_bank_ram_mapper.sv
module test_bank_ram_mapper;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] reqAddr = '0;
  logic        dispSlot = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrData = '0;
  logic        rdEn = 1'b0;
  logic [1:0]  rdData;
  logic [17:0] ramAddr;

  int testsRun = 0;
  int testsFailed = 0;
  int refBank = 0;
  int refRd = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #10 clk = ~clk;

  bank_ram_mapper i_bank_ram_mapper (
    .clk (clk), .rstN (rstN), .reqAddr (reqAddr), .dispSlot (dispSlot),
    .wrEn (wrEn), .wrData (wrData), .rdEn (rdEn), .rdData (rdData),
    .ramAddr (ramAddr)
  );

  task automatic check(input string req, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One access cycle: drive at negedge, check outputs, advance model at posedge.
  task automatic step(input bit disp, input logic [15:0] a, input bit wr,
                      input logic [1:0] wd, input bit rd, input string tag);
    @(negedge clk);
    dispSlot = disp; reqAddr = a; wrEn = wr; wrData = wd; rdEn = rd;
    #2;
    check({tag, " R2 low address"}, int'(ramAddr[15:0]), int'(a));
    if (disp) check({tag, " R4 display bank"}, int'(ramAddr[17:16]), 3);
    else      check({tag, " R3 cpu bank"}, int'(ramAddr[17:16]), refBank);
    check({tag, " R8 readback"}, int'(rdData), refRd);
    @(posedge clk);
    if (rd) refRd = refBank;
    if (wr) refBank = int'(wd);
  endtask

  initial begin
    #2_000_000;
    testsFailed++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    reqAddr = 16'h1234; #2;
    check("R1 bank in reset", int'(ramAddr[17:16]), 0);
    check("R1 rdData in reset", int'(rdData), 0);
    rstN = 1'b1;
    step(0, 16'hBEEF, 0, 2'd0, 1, "R1");
    step(0, 16'h0000, 0, 2'd0, 0, "R1");
    step(1, 16'hFFFF, 0, 2'd0, 0, "R4");
    // R5: write with same-cycle access, then new bank visible
    step(0, 16'h0100, 1, 2'd2, 0, "R5");
    step(0, 16'h0101, 0, 2'd0, 0, "R5");
    // R6: write during display slot
    step(1, 16'h8000, 1, 2'd1, 0, "R6");
    step(1, 16'h8001, 0, 2'd0, 0, "R6");
    step(0, 16'h8002, 0, 2'd0, 0, "R6");
    // R7: display slot between cpu accesses
    step(1, 16'h4000, 0, 2'd0, 0, "R7");
    step(0, 16'h4001, 0, 2'd0, 0, "R7");
    // R8: read with simultaneous write returns old value
    step(0, 16'h0002, 1, 2'd3, 1, "R8");
    step(0, 16'h0003, 0, 2'd0, 0, "R8");
    step(0, 16'h0004, 0, 2'd0, 1, "R8");
    step(0, 16'h0005, 1, 2'd0, 0, "R8");
    step(0, 16'h0006, 0, 2'd0, 0, "R8");
    // R9: long run without strobes
    for (int i = 0; i < 20; i++)
      step(i % 3 == 0, 16'(i * 16'h0777), 0, 2'd0, 0, "R9");
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(lfsr[0], lfsr[23:8], lfsr[3] & lfsr[4], lfsr[6:5], lfsr[7] & lfsr[2], "mix");
    end
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule